// File: doc/BRIEF.md
# Masked Level/Edge Trigger Matcher

The block watches a parallel logic sample stream and decides, sample by sample, whether a capture trigger condition is met. Each channel can take part in the condition or be ignored. A channel that takes part matches either on a level, meaning its current value equals a target bit, or on an edge, meaning it has just moved onto the target bit. The trigger fires when every participating channel matches on the same valid sample. It then produces a single pulse and sets a flag that stays set, so later matching samples produce no further pulses.

Two 32-bit words configure the block. The select word carries the per-channel edge flags in its upper half and the per-channel target values in its lower half. The control word carries the per-channel participation mask in its upper half and the enable in bit 2. Any write to the control word re-arms the matcher. A control write with a zero enable bit switches it off.

Top module: `trig_matcher`

## Requirements
- R1: After reset, trig_o and triggered_o are 0, all configuration fields are 0 and the previous-sample register is 0.
- R2: A participating channel whose edge flag is 0 matches when its current sample bit equals its target bit (select word bits [15:0], channel i at bit i).
- R3: A participating channel whose edge flag is 1 (select word bits [31:16], channel i at bit 16+i) matches only when its previous valid sample bit differs from the target bit and its current sample bit equals it.
- R4: A channel whose participation bit is 0 (control word bits [31:16], channel i at bit 16+i) has no effect on the outcome.
- R5: The trigger fires only when every participating channel matches on the same valid sample.
- R6: With no channel participating, the trigger fires on the first valid sample after enable.
- R7: Cycles with smp_vld_i low never fire the trigger and leave the previous-sample register unchanged.
- R8: A firing sample makes trig_o high for exactly one cycle, starting the cycle after the sample is taken, and triggered_o rises in that same cycle.
- R9: Once triggered_o is set, it stays set and no further trig_o pulses occur until the next control-word write.
- R10: While the enable bit (control word bit 2) is 0, the trigger never fires. A control write with bit 2 clear disables triggering.
- R11: Any control-word write clears triggered_o on the next cycle and re-arms the matcher, and no trigger fires in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | CH_W | Sample bus, one bit per channel |
| smp_vld_i | input | 1 | Sample bus carries a new sample |
| sel_we_i | input | 1 | Write strobe for the select word |
| sel_wdata_i | input | 32 | Select word: edge flags [31:16], target values [15:0] |
| ctl_we_i | input | 1 | Write strobe for the control word |
| ctl_wdata_i | input | 32 | Control word: participation mask [31:16], enable bit 2 |
| trig_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Sticky triggered flag |

## Verification
The bench builds the matcher with CH_W=4. At that width, every combination of target, edge flag and participation mask across all channels is swept (4096 configurations). Each configuration is tried with a chosen previous sample and two current samples, and the expected trigger is derived bit by bit in the bench. Directed sequences cover the empty mask, invalid cycles that must not update the edge history, stickiness against later matches, disable and re-arm.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned HALF_W     = REG_W / 2;
  localparam int unsigned EN_BIT_POS = 2;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int unsigned CH_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [REG_W-1:0] sel_wdata_i,
  input  logic             ctl_we_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  output logic [CH_W-1:0]  edge_o,
  output logic [CH_W-1:0]  tgt_o,
  output logic [CH_W-1:0]  part_o,
  output logic             en_o
);
  logic [CH_W-1:0] edge_q, tgt_q, part_q;
  logic            en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      tgt_q  <= '0;
    end else if (sel_we_i) begin
      edge_q <= sel_wdata_i[HALF_W +: CH_W];
      tgt_q  <= sel_wdata_i[0 +: CH_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q <= '0;
      en_q   <= 1'b0;
    end else if (ctl_we_i) begin
      part_q <= ctl_wdata_i[HALF_W +: CH_W];
      en_q   <= ctl_wdata_i[EN_BIT_POS];
    end
  end

  assign edge_o = edge_q;
  assign tgt_o  = tgt_q;
  assign part_o = part_q;
  assign en_o   = en_q;

  p_ctl_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (en_o == $past(ctl_wdata_i[EN_BIT_POS])));
  p_ctl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(en_o));
endmodule

// File: rtl/trig_chan_match.sv
module trig_chan_match #(
  parameter int unsigned CH_W = 16
) (
  input  logic [CH_W-1:0] cur_i,
  input  logic [CH_W-1:0] prev_i,
  input  logic [CH_W-1:0] tgt_i,
  input  logic [CH_W-1:0] edge_i,
  input  logic [CH_W-1:0] part_i,
  output logic [CH_W-1:0] ch_ok_o,
  output logic            hit_o
);
  for (genvar i = 0; i < CH_W; i++) begin : g_ch
    logic lvl_eq, was_off;
    assign lvl_eq  = (cur_i[i] == tgt_i[i]);
    assign was_off = (prev_i[i] != tgt_i[i]);
    // Non-participating channels are forced to pass.
    assign ch_ok_o[i] = !part_i[i] || (edge_i[i] ? (lvl_eq && was_off) : lvl_eq);
  end

  assign hit_o = &ch_ok_o;

  always_comb begin
    if (part_i == '0) begin
      a_empty_mask_r6: assert (hit_o);
    end
  end
endmodule

// File: rtl/trig_fire_ctrl.sv
module trig_fire_ctrl #(
  parameter int unsigned CH_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] smp_i,
  input  logic            smp_vld_i,
  input  logic            en_i,
  input  logic            rearm_i,
  input  logic            hit_i,
  output logic [CH_W-1:0] prev_o,
  output logic            trig_o,
  output logic            flag_o
);
  logic [CH_W-1:0] prev_q;
  logic            flag_q, pulse_q, fire;

  assign fire = en_i && !flag_q && smp_vld_i && hit_i && !rearm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else if (smp_vld_i) begin
      prev_q <= smp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (rearm_i) begin
        flag_q <= 1'b0;
      end else if (fire) begin
        flag_q <= 1'b1;
      end
    end
  end

  assign prev_o = prev_q;
  assign trig_o = pulse_q;
  assign flag_o = flag_q;

  p_prev_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> $stable(prev_o));
  p_no_fire_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> !trig_o);
  p_pulse_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  p_pulse_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> flag_o);
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !rearm_i) |=> (flag_o && !trig_o));
  p_no_fire_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !trig_o);
  p_rearm_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (!flag_o && !trig_o));
  p_fire_on_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(hit_i && smp_vld_i));
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher
  import trig_pkg::*;
#(
  parameter int unsigned CH_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CH_W-1:0]  smp_i,
  input  logic             smp_vld_i,
  input  logic             sel_we_i,
  input  logic [REG_W-1:0] sel_wdata_i,
  input  logic             ctl_we_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  output logic             trig_o,
  output logic             triggered_o
);
  logic [CH_W-1:0] edge_m, tgt_v, part_m, prev_s, ch_ok;
  logic            en, hit;

  trig_cfg_regs #(.CH_W(CH_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_we_i    (sel_we_i),
    .sel_wdata_i (sel_wdata_i),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .edge_o      (edge_m),
    .tgt_o       (tgt_v),
    .part_o      (part_m),
    .en_o        (en)
  );

  trig_chan_match #(.CH_W(CH_W)) u_match (
    .cur_i   (smp_i),
    .prev_i  (prev_s),
    .tgt_i   (tgt_v),
    .edge_i  (edge_m),
    .part_i  (part_m),
    .ch_ok_o (ch_ok),
    .hit_o   (hit)
  );

  trig_fire_ctrl #(.CH_W(CH_W)) u_fire (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_i     (smp_i),
    .smp_vld_i (smp_vld_i),
    .en_i      (en),
    .rearm_i   (ctl_we_i),
    .hit_i     (hit),
    .prev_o    (prev_s),
    .trig_o    (trig_o),
    .flag_o    (triggered_o)
  );

  p_quiet_when_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !ctl_we_i) |=> !triggered_o || $past(triggered_o));
endmodule

// File: tb/trig_matcher_tb.sv
`timescale 1ns/1ps
module trig_matcher_tb;
  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] smp = '0;
  logic          vld = 1'b0;
  logic          sel_we = 1'b0;
  logic [31:0]   sel_wd = '0;
  logic          ctl_we = 1'b0;
  logic [31:0]   ctl_wd = '0;
  logic          trig, trgd;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  trig_matcher #(.CH_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .smp_vld_i(vld),
    .sel_we_i(sel_we), .sel_wdata_i(sel_wd), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
    .trig_o(trig), .triggered_o(trgd)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: trig/triggered actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr_sel(input logic [CW-1:0] e, input logic [CW-1:0] t);
    @(negedge clk);
    sel_we = 1'b1;
    sel_wd = '0;
    sel_wd[16 +: CW] = e;
    sel_wd[0 +: CW] = t;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [CW-1:0] p, input logic en);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wd = '0;
    ctl_wd[16 +: CW] = p;
    ctl_wd[2] = en;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // Present one sample; returns at the next negedge, when a pulse would be visible.
  task automatic put(input logic [CW-1:0] s, input logic v);
    @(negedge clk);
    smp = s;
    vld = v;
    @(negedge clk);
    vld = 1'b0;
  endtask

  function automatic logic model(input logic [CW-1:0] p, input logic [CW-1:0] e,
                                 input logic [CW-1:0] t, input logic [CW-1:0] pv,
                                 input logic [CW-1:0] c);
    logic ok = 1'b1;
    for (int i = 0; i < CW; i++) begin
      if (p[i]) begin
        if (e[i]) ok &= (pv[i] != t[i]) && (c[i] == t[i]);
        else      ok &= (c[i] == t[i]);
      end
    end
    return ok;
  endfunction

  initial begin
    #(5.0 * 190000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {trig, trgd}, 2'b00);
    rst_n = 1'b1;
    // R1: enable alone with zero config: level match on target 0 is the empty-mask case
    put(4'hF, 1'b1);
    chk("R1 idle after reset", {trig, trgd}, 2'b00);

    // R6: empty mask fires on the first valid sample after enable
    wr_ctl(4'h0, 1'b1);
    chk("R11 armed", {trig, trgd}, 2'b00);
    put(4'h0, 1'b0);
    chk("R7 invalid no fire", {trig, trgd}, 2'b00);
    put(4'h9, 1'b1);
    chk("R6 empty mask fires", {trig, trgd}, 2'b11);
    @(negedge clk);
    chk("R8 single pulse", {trig, trgd}, 2'b01);
    put(4'h9, 1'b1);
    chk("R9 sticky no repulse", {trig, trgd}, 2'b01);

    // R10: control write with enable clear
    wr_ctl(4'h0, 1'b0);
    chk("R10 disable clears flag", {trig, trgd}, 2'b00);
    put(4'h3, 1'b1);
    chk("R10 disabled no fire", {trig, trgd}, 2'b00);

    // R7: invalid cycle must not update edge history
    wr_sel(4'h1, 4'h1);
    put(4'h0, 1'b1);
    wr_ctl(4'h1, 1'b1);
    put(4'h1, 1'b0);
    chk("R7 invalid target no fire", {trig, trgd}, 2'b00);
    put(4'h1, 1'b1);
    chk("R7 R3 edge after invalid", {trig, trgd}, 2'b11);
    // R11: re-arm with enable kept, history now at target so edge cannot fire
    wr_ctl(4'h1, 1'b1);
    chk("R11 rearm clears", {trig, trgd}, 2'b00);
    put(4'h1, 1'b1);
    chk("R3 no edge when held", {trig, trgd}, 2'b00);
    put(4'h0, 1'b1);
    put(4'h1, 1'b1);
    chk("R3 new edge fires", {trig, trgd}, 2'b11);

    // Sweep: R2 R3 R4 R5 over every target, edge and participation mask
    for (int k = 0; k < 4096; k++) begin
      logic [CW-1:0] t, e, p, pv, c0, c1;
      logic x;
      t  = k[3:0];
      e  = k[7:4];
      p  = k[11:8];
      pv = t ^ e ^ k[11:8] ^ 4'(k >> 2);
      c0 = t;
      c1 = t ^ (4'h1 << k[1:0]);
      wr_sel(e, t);
      wr_ctl(p, 1'b0);
      put(pv, 1'b1);
      wr_ctl(p, 1'b1);
      x = model(p, e, t, pv, c0);
      put(c0, 1'b1);
      chk("R2 R3 R4 R5 sweep c=t", {trig, trgd}, {x, x});
      wr_ctl(p, 1'b0);
      put(pv, 1'b1);
      wr_ctl(p, 1'b1);
      x = model(p, e, t, pv, c1);
      put(c1, 1'b1);
      chk("R2 R3 R4 R5 sweep c=t^bit", {trig, trgd}, {x, x});
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule